// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block sits in a small register map and gives a host bus indirect reach into two larger spaces through one index word and a four-byte data window. The host first stores a 32-bit pointer in the index word. Every later access to the window is then forwarded: to the internal register file when pointer bit 31 is clear, or to a linear video memory when it is set. The block carries out no register or memory function itself. It steers, sizes and aligns each access and waits for the target.

The host bus carries byte, halfword and word accesses. Data travels right-justified: a byte access uses bits 7:0 and a halfword uses bits 15:0. The register-file port is word-addressed, with a byte-strobe, so a narrow access reaches the correct lane of a 32-bit register. The memory port is byte-addressed and carries a size code. Every memory access is first checked against the size of the memory. An access that does not fit is absorbed by the block and never reaches the memory.

All three edges use valid/ready. A request is held with stable fields until the receiver asserts ready. A read response is held with stable data until the host asserts `rsp_ready`. Only one host access is in flight at a time: `bus_ready` stays low from acceptance until that access has finished.

Top module: `index_window`

## Requirements
- R1: The index word is reached at bus addresses whose bit 2 is 0. A write stores all 32 bits of `bus_wdata` whatever the size code. A read returns all 32 stored bits. Reset clears the index to zero.
- R2: The window is reached at bus addresses whose bit 2 is 1, and k = `bus_addr[1:0]` is the window offset. Size code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes. Bus data is right-justified.
- R3: With index bit 31 clear, one register request is issued. Let S = index + k. The word address is `S[REG_AW+1:2]` and the lane is L = `S[1:0]`. The strobe has one bit per accessed byte, starting at lane L. Bytes that would fall beyond lane 3 are dropped. Write data is moved up by 8*L bits.
- R4: A register read returns the target word shifted down by 8*L bits and masked to the access size. Lanes beyond lane 3 read as zero.
- R5: With index bit 31 set, one memory request is issued at byte address `index[MEM_AW-1:0]`, whatever k is. It carries the bus size code and write data masked to the access size.
- R6: A memory access goes ahead only if `index[30:0] <= MEM_BYTES - bytes`. Otherwise no memory request is issued, a write is dropped, and a read returns 0.
- R7: Memory read data has its lowest-addressed byte in bits 7:0. The block masks it to the access size.
- R8: A target request holds valid and its fields stable until ready. A write completes at that handshake. A read then waits for the target's read-valid pulse.
- R9: `bus_ready` is low from acceptance until the access completes. Each read produces exactly one response, held with stable data until `rsp_ready`.
- R10: An index read or a bounds-failed read responds in the cycle after acceptance. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access request valid |
| bus_ready | output | 1 | Block can accept an access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address in the map (bit 2 picks the window) |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_rdata | output | 32 | Right-justified read data |
| reg_valid | output | 1 | Register-file request valid |
| reg_ready | input | 1 | Register file takes the request |
| reg_write | output | 1 | Register request is a write |
| reg_addr | output | REG_AW | Register word address |
| reg_be | output | 4 | Byte strobe per lane |
| reg_wdata | output | 32 | Lane-aligned write data |
| reg_rvalid | input | 1 | Register read data valid |
| reg_rdata | input | 32 | Register read data (whole word) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_size | output | 2 | Size code, same encoding as bus_size |
| mem_wdata | output | 32 | Size-masked write data, first byte in bits 7:0 |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data, first byte in bits 7:0 |

## Verification
An index write takes effect in the cycle after acceptance. An index read, or a read that fails the bounds check, has its response valid one cycle after acceptance. The bench counts the falling edges from acceptance and requires exactly one for these local reads. Target accesses depend on the ready and read-valid timing of the target models, so those reads are checked on their data at whatever edge `rsp_valid` first appears. Target requests are compared field by field on every falling edge against the expected request, and any request at a moment when none is expected counts as a failure. `bus_ready` is checked low on the edge after a forwarded access is accepted.

// File: rtl/ixw_pkg.sv
package ixw_pkg;
  localparam int BUS_AW = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RSP} ixw_state_t;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] bytes_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [3:0] bytes_strobe(input logic [2:0] n);
    case (n)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/ixw_route.sv
module ixw_route
  import ixw_pkg::*;
#(
  parameter int REG_AW    = 12,
  parameter int MEM_BYTES = 65536,
  parameter int MEM_AW    = 16
) (
  input  logic [31:0]       index,
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic              to_mem,
  output logic              mem_ok,
  output logic [2:0]        nbytes,
  output logic [1:0]        lane,
  output logic [REG_AW-1:0] reg_addr,
  output logic [3:0]        reg_be,
  output logic [31:0]       reg_wdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int SUM_W = REG_AW + 2;

  logic [SUM_W-1:0] sum;
  logic [7:0]       be_wide;
  logic [31:0]      lim;

  always_comb begin
    nbytes    = size_to_bytes(size);
    // register side: pointer plus window offset, split into word and lane
    sum       = index[SUM_W-1:0] + SUM_W'(off);
    lane      = sum[1:0];
    reg_addr  = sum[SUM_W-1:2];
    be_wide   = {4'd0, bytes_strobe(nbytes)} << lane;
    reg_be    = be_wide[3:0];
    reg_wdata = wdata << {lane, 3'b000};
    // memory side: pointer alone, bounds against the last legal start
    to_mem    = index[31];
    lim       = 32'(MEM_BYTES) - {29'd0, nbytes};
    mem_ok    = ({1'b0, index[30:0]} <= lim);
    mem_addr  = index[MEM_AW-1:0];
    mem_wdata = wdata & bytes_mask(nbytes);
  end
endmodule

// File: rtl/ixw_lanes.sv
module ixw_lanes
  import ixw_pkg::*;
(
  input  logic        from_mem,
  input  logic [1:0]  lane,
  input  logic [2:0]  nbytes,
  input  logic [31:0] reg_rdata,
  input  logic [31:0] mem_rdata,
  output logic [31:0] rdata
);
  always_comb begin
    if (from_mem) rdata = mem_rdata & bytes_mask(nbytes);
    else          rdata = (reg_rdata >> {lane, 3'b000}) & bytes_mask(nbytes);
  end
endmodule

// File: rtl/ixw_seq.sv
module ixw_seq
  import ixw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       index,
  output logic [1:0]        sel_off,
  output logic [1:0]        sel_size,
  output logic [31:0]       sel_wdata,
  input  logic              to_mem,
  input  logic              mem_ok,
  output logic              tgt_mem,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_write,
  input  logic              reg_rvalid,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  input  logic              mem_rvalid,
  input  logic [31:0]       tgt_rdata
);
  ixw_state_t  state;
  logic [31:0] index_q, cap_wdata, rsp_q;
  logic [1:0]  cap_off, cap_size;
  logic        cap_write, tgt_mem_q;
  logic        accept, hs, rback, is_idle, win_sel;

  always_comb begin
    is_idle   = (state == ST_IDLE);
    bus_ready = is_idle;
    accept    = bus_valid && is_idle;
    win_sel   = bus_addr[BUS_AW-1];
    // route sees the live bus fields while idle so the decision costs no cycle
    sel_off   = is_idle ? bus_addr[1:0] : cap_off;
    sel_size  = is_idle ? bus_size      : cap_size;
    sel_wdata = is_idle ? bus_wdata     : cap_wdata;
    reg_valid = (state == ST_ISSUE) && !tgt_mem_q;
    mem_valid = (state == ST_ISSUE) &&  tgt_mem_q;
    reg_write = cap_write;
    mem_write = cap_write;
    hs        = (reg_valid && reg_ready) || (mem_valid && mem_ready);
    rback     = tgt_mem_q ? mem_rvalid : reg_rvalid;
    rsp_valid = (state == ST_RSP);
    rsp_rdata = rsp_q;
    index     = index_q;
    tgt_mem   = tgt_mem_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      index_q   <= '0;
      cap_wdata <= '0;
      cap_off   <= '0;
      cap_size  <= '0;
      cap_write <= 1'b0;
      tgt_mem_q <= 1'b0;
      rsp_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          cap_off   <= bus_addr[1:0];
          cap_size  <= bus_size;
          cap_wdata <= bus_wdata;
          cap_write <= bus_write;
          tgt_mem_q <= to_mem;
          if (!win_sel) begin
            if (bus_write) index_q <= bus_wdata;
            else begin
              rsp_q <= index_q;
              state <= ST_RSP;
            end
          end else if (to_mem && !mem_ok) begin
            if (!bus_write) begin
              rsp_q <= '0;
              state <= ST_RSP;
            end
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (hs) state <= cap_write ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (rback) begin
          rsp_q <= tgt_rdata;
          state <= ST_RSP;
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  a_r1_index_store: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bus_write && !win_sel) |=> (index_q == $past(bus_wdata)));

  a_r10_index_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bus_write && !win_sel) |=> (rsp_valid && rsp_rdata == $past(index_q)));

  a_r6_bound_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_sel && to_mem && !mem_ok) |=> (!mem_valid && !reg_valid));

  a_r6_bound_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_sel && to_mem && !mem_ok && !bus_write) |=> (rsp_valid && rsp_rdata == 32'd0));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r9_busy_during_target: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid || mem_valid) |-> !bus_ready);

  a_r8_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_valid && !reg_ready) || (mem_valid && !mem_ready)) |=>
      ($stable(reg_valid) && $stable(mem_valid) && $stable(sel_off) &&
       $stable(sel_size) && $stable(sel_wdata)));
endmodule

// File: rtl/index_window.sv
module index_window
  import ixw_pkg::*;
#(
  parameter int REG_AW    = 12,
  parameter int MEM_BYTES = 65536,
  parameter int MEM_AW    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [2:0]        bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_write,
  output logic [REG_AW-1:0] reg_addr,
  output logic [3:0]        reg_be,
  output logic [31:0]       reg_wdata,
  input  logic              reg_rvalid,
  input  logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  logic [31:0] index, sel_wdata, tgt_rdata;
  logic [1:0]  sel_off, sel_size, lane;
  logic [2:0]  nbytes;
  logic        to_mem, mem_ok, tgt_mem;

  ixw_seq u_seq (
    .clk, .rst_n,
    .bus_valid, .bus_ready, .bus_write, .bus_addr, .bus_size, .bus_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .index, .sel_off, .sel_size, .sel_wdata,
    .to_mem, .mem_ok, .tgt_mem,
    .reg_valid, .reg_ready, .reg_write, .reg_rvalid,
    .mem_valid, .mem_ready, .mem_write, .mem_rvalid,
    .tgt_rdata
  );

  ixw_route #(.REG_AW(REG_AW), .MEM_BYTES(MEM_BYTES), .MEM_AW(MEM_AW)) u_route (
    .index, .off(sel_off), .size(sel_size), .wdata(sel_wdata),
    .to_mem, .mem_ok, .nbytes, .lane,
    .reg_addr, .reg_be, .reg_wdata, .mem_addr, .mem_wdata
  );

  ixw_lanes u_lanes (
    .from_mem(tgt_mem), .lane, .nbytes,
    .reg_rdata, .mem_rdata, .rdata(tgt_rdata)
  );

  assign mem_size = sel_size;

  a_r6_mem_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((32'(mem_addr) + 32'(size_to_bytes(mem_size))) <= 32'(MEM_BYTES)));

  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && mem_valid));

  a_r3_strobe_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (reg_be != 4'b0000));
endmodule

// File: tb/sim_index_window.sv
`timescale 1ns/1ps
module sim_index_window;
  localparam int REG_AW = 6, MEM_BYTES = 256, MEM_AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic reg_valid, reg_ready, reg_write, reg_rvalid;
  logic [REG_AW-1:0] reg_addr;
  logic [3:0] reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_valid, mem_ready, mem_write, mem_rvalid;
  logic [MEM_AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  int nchk = 0, nerr = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  index_window #(.REG_AW(REG_AW), .MEM_BYTES(MEM_BYTES)) u0 (.*);

  // target models: stores driven by the DUT's request ports
  logic [31:0] reg_store [64];
  logic [7:0]  mem_store [256];
  logic [31:0] ref_reg [64];
  logic [7:0]  ref_mem [256];
  logic [31:0] ref_idx = 0;
  logic rpend = 0, mpend = 0;
  int rcnt = 0, mcnt = 0;
  logic [5:0] raddr_q;
  logic [7:0] maddr_q;

  assign reg_ready = (cyc % 3) != 0;
  assign mem_ready = (cyc % 2) == 0;

  initial begin
    for (int i = 0; i < 64; i++) begin reg_store[i] = 32'hA5A5_0000 + i; ref_reg[i] = 32'hA5A5_0000 + i; end
    for (int i = 0; i < 256; i++) begin mem_store[i] = 8'(i) ^ 8'h3C; ref_mem[i] = 8'(i) ^ 8'h3C; end
    reg_rvalid = 0; mem_rvalid = 0; reg_rdata = 0; mem_rdata = 0;
  end

  always @(posedge clk) begin
    reg_rvalid <= 1'b0;
    mem_rvalid <= 1'b0;
    if (reg_valid && reg_ready) begin
      if (reg_write) begin
        for (int b = 0; b < 4; b++) if (reg_be[b]) reg_store[reg_addr][8*b +: 8] <= reg_wdata[8*b +: 8];
      end else begin rpend <= 1; rcnt <= 2; raddr_q <= reg_addr; end
    end else if (rpend) begin
      if (rcnt == 0) begin reg_rvalid <= 1'b1; reg_rdata <= reg_store[raddr_q]; rpend <= 0; end
      else rcnt <= rcnt - 1;
    end
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int b = 0; b < 4; b++)
          if (b < ((mem_size == 0) ? 1 : (mem_size == 1) ? 2 : 4)) mem_store[mem_addr + 8'(b)] <= mem_wdata[8*b +: 8];
      end else begin mpend <= 1; mcnt <= 1; maddr_q <= mem_addr; end
    end else if (mpend) begin
      if (mcnt == 0) begin
        mem_rvalid <= 1'b1;
        for (int b = 0; b < 4; b++) mem_rdata[8*b +: 8] <= mem_store[maddr_q + 8'(b)];
        mpend <= 0;
      end else mcnt <= mcnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected target request, compared on every falling edge
  int exp_tgt = 0;
  logic exp_wr = 0;
  logic [5:0] exp_raddr;
  logic [3:0] exp_be;
  logic [31:0] exp_rwdata, exp_mwdata;
  logic [7:0] exp_maddr;
  logic [1:0] exp_msize;

  always @(negedge clk) if (rst_n) begin
    if (reg_valid) begin
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{exp_be[b]}};
      chk("R8 register request expected", 32'(exp_tgt), 32'd1);
      chk("R3 register word address", 32'(reg_addr), 32'(exp_raddr));
      chk("R3 register byte strobe", 32'(reg_be), 32'(exp_be));
      chk("R8 register write flag", 32'(reg_write), 32'(exp_wr));
      if (exp_wr) chk("R3 register write lanes", reg_wdata & m, exp_rwdata & m);
    end
    if (mem_valid) begin
      chk("R8 memory request expected", 32'(exp_tgt), 32'd2);
      chk("R5 memory byte address", 32'(mem_addr), 32'(exp_maddr));
      chk("R5 memory size code", 32'(mem_size), 32'(exp_msize));
      chk("R8 memory write flag", 32'(mem_write), 32'(exp_wr));
      if (exp_wr) chk("R5 memory write data", mem_wdata, exp_mwdata);
    end
  end

  task automatic do_acc(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag, input int hold);
    logic [31:0] exp_rd, got, s;
    int nb, lat, base, lane;
    logic loc;
    exp_rd = 0; loc = 0;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    exp_tgt = 0; exp_wr = wr;
    if (!a[2]) begin
      loc = 1;
      if (wr) ref_idx = wd; else exp_rd = ref_idx;
    end else if (ref_idx[31]) begin
      base = int'(ref_idx[30:0]);
      if (base <= MEM_BYTES - nb) begin
        exp_tgt = 2; exp_maddr = 8'(base); exp_msize = sz; exp_mwdata = 0;
        for (int i = 0; i < nb; i++) begin
          exp_mwdata[8*i +: 8] = wd[8*i +: 8];
          if (wr) ref_mem[base + i] = wd[8*i +: 8]; else exp_rd[8*i +: 8] = ref_mem[base + i];
        end
      end else loc = 1;
    end else begin
      s = ref_idx + 32'(a[1:0]);
      lane = int'(s[1:0]);
      exp_tgt = 1; exp_raddr = s[7:2]; exp_be = 0; exp_rwdata = 0;
      for (int i = 0; i < nb; i++) if (lane + i < 4) begin
        exp_be[lane + i] = 1'b1;
        exp_rwdata[8*(lane + i) +: 8] = wd[8*i +: 8];
        if (wr) ref_reg[s[7:2]][8*(lane + i) +: 8] = wd[8*i +: 8];
        else exp_rd[8*i +: 8] = ref_reg[s[7:2]][8*(lane + i) +: 8];
      end
    end
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0;
    if (wr) begin
      chk({tag, " R10 no write response"}, 32'(rsp_valid), 32'd0);
      if (exp_tgt != 0) chk({tag, " R9 busy after accept"}, 32'(bus_ready), 32'd0);
      while (!bus_ready) @(negedge clk);
    end else begin
      lat = 1;
      while (!rsp_valid) begin @(negedge clk); lat++; end
      if (loc) chk({tag, " R10 local latency"}, 32'(lat), 32'd1);
      got = rsp_rdata;
      chk(tag, got, exp_rd);
      if (hold > 0) begin
        rsp_ready = 0;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk("R9 response held valid", 32'(rsp_valid), 32'd1);
          chk("R9 response data stable", rsp_rdata, got);
        end
        rsp_ready = 1;
      end
      @(negedge clk);
      chk({tag, " R9 single response"}, 32'(rsp_valid), 32'd0);
    end
    exp_tgt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset bus_ready", 32'(bus_ready), 32'd1);
    chk("R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R8 reset no requests", 32'({reg_valid, mem_valid}), 32'd0);
    rst_n = 1;
    do_acc(0, 3'd0, 2'd2, 0, "R1 index reset value", 0);
    do_acc(1, 3'd0, 2'd0, 32'h1234_5610, "R1 index write", 0);
    do_acc(0, 3'd0, 2'd0, 0, "R1 index full-word read", 0);
    do_acc(1, 3'd0, 2'd2, 32'h0000_0010, "R1 index write", 0);
    // register space
    do_acc(1, 3'd4, 2'd2, 32'hDEAD_BEEF, "R3 word write", 0);
    do_acc(0, 3'd4, 2'd2, 0, "R4 word read", 0);
    do_acc(1, 3'd5, 2'd0, 32'h0000_0011, "R3 byte write k1", 0);
    do_acc(1, 3'd6, 2'd0, 32'h0000_0022, "R3 byte write k2", 0);
    do_acc(0, 3'd4, 2'd2, 0, "R3 deposit keeps other bits", 0);
    do_acc(0, 3'd6, 2'd1, 0, "R4 halfword read k2", 0);
    do_acc(0, 3'd7, 2'd0, 0, "R4 byte read k3", 0);
    do_acc(0, 3'd5, 2'd1, 0, "R2 halfword read k1", 0);
    do_acc(1, 3'd0, 2'd2, 32'h0000_0013, "R1 index write", 0);
    do_acc(0, 3'd4, 2'd1, 0, "R4 lane beyond word reads zero", 0);
    do_acc(1, 3'd4, 2'd1, 32'h0000_7788, "R3 crossing write drops lane", 0);
    do_acc(0, 3'd5, 2'd3, 0, "R3 index plus offset carries word", 0);
    do_acc(1, 3'd0, 2'd2, 32'h0000_0010, "R1 index write", 0);
    do_acc(0, 3'd4, 2'd2, 0, "R3 crossing write result", 3);
    // memory space
    do_acc(1, 3'd0, 2'd2, 32'h8000_0020, "R1 index write", 0);
    do_acc(1, 3'd4, 2'd2, 32'h4433_2211, "R5 memory word write", 0);
    do_acc(0, 3'd7, 2'd0, 0, "R5 window offset ignored", 0);
    do_acc(0, 3'd4, 2'd1, 0, "R7 memory halfword masked", 0);
    do_acc(0, 3'd4, 2'd2, 0, "R7 memory little-endian word", 2);
    do_acc(1, 3'd0, 2'd2, 32'h8000_00FC, "R1 index write", 0);
    do_acc(0, 3'd4, 2'd2, 0, "R6 last legal word", 0);
    do_acc(1, 3'd0, 2'd2, 32'h8000_00FD, "R1 index write", 0);
    do_acc(0, 3'd4, 2'd2, 0, "R6 word over bound reads zero", 0);
    do_acc(1, 3'd4, 2'd1, 32'h0000_BEEF, "R6 halfword within bound", 0);
    do_acc(1, 3'd0, 2'd2, 32'h8000_00FE, "R1 index write", 0);
    do_acc(1, 3'd4, 2'd2, 32'hCAFE_F00D, "R6 word write dropped", 0);
    do_acc(0, 3'd4, 2'd0, 0, "R6 dropped write left memory", 0);
    do_acc(1, 3'd0, 2'd2, 32'h8000_00FF, "R1 index write", 0);
    do_acc(0, 3'd4, 2'd0, 0, "R6 last byte legal", 0);
    do_acc(0, 3'd4, 2'd1, 0, "R6 halfword over bound", 0);
    do_acc(1, 3'd0, 2'd2, 32'h8001_0000, "R1 index write", 0);
    do_acc(0, 3'd4, 2'd0, 0, "R6 high pointer bits out of range", 2);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule